// File: doc/BRIEF.md
# Single-Error-Correcting Hamming Codec for Byte Words

This block protects byte-wide words on their way into and out of a memory. On the store path a purely combinational encoder turns the 8 data bits into a 12-bit codeword. Four parity bits sit at the power-of-two positions, and the data bits fill the remaining positions in ascending order. On the load path the fetched codeword enters a registered decode stage. That stage recomputes the parity from the fetched data bits and XORs it with the fetched parity to form a 4-bit syndrome. It then repairs the single faulty bit that the syndrome points at and classifies the event.

A nonzero syndrome is a 1-based position inside the codeword, so one mechanism covers both cases: a fault in a data bit and a fault in a parity bit. The block does not detect double errors and holds no storage of its own. The load result appears one clock after it is presented, framed by a valid strobe.

Top module: `sec12_codec`

## Requirements
- R1: Codeword bit index i holds position i+1. Parity bits P1, P2, P4 and P8 sit at indices 0, 1, 3 and 7. Data bits 0..7 sit at indices 2, 4, 5, 6, 8, 9, 10 and 11 in that order. `st_code` always reflects the current `st_data`.
- R2: Parity bit Pn is the XOR of the data bits whose position number has the binary digit of weight n set. Examples: P1 covers positions 3, 5, 7, 9 and 11; P8 covers positions 9 through 12.
- R3: `ld_syndrome` equals the fetched parity XOR the parity recomputed from the fetched data bits. For a codeword with exactly one flipped bit at position p, it equals p.
- R4: With a zero syndrome, `ld_data` equals the fetched data bits, and `ld_err`, `ld_par_fix` and `ld_uncorr` are all low.
- R5: With a syndrome of 3, 5, 6, 7, 9, 10, 11 or 12, the data bit at that position is inverted before output. `ld_err` is high; `ld_par_fix` and `ld_uncorr` are low.
- R6: With a syndrome of 1, 2, 4 or 8, `ld_data` equals the fetched data bits, `ld_err` and `ld_par_fix` are high, and `ld_uncorr` is low.
- R7: With a syndrome of 13, 14 or 15, `ld_data` equals the fetched data bits, `ld_err` and `ld_uncorr` are high, and `ld_par_fix` is low.
- R8: `ld_valid_out` is high exactly in the cycle after `ld_valid_in` was sampled high. Load outputs keep their values through cycles without `ld_valid_in`.
- R9: While reset is asserted, and until the first accepted load, `ld_valid_out` and all load outputs are zero. Reset asserts asynchronously and releases on the second clock edge after `rst_n` rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| st_data | input | 8 | Data word to be stored |
| st_code | output | 12 | Encoded codeword for storage |
| ld_valid_in | input | 1 | Fetched codeword is present |
| ld_code | input | 12 | Fetched codeword |
| ld_valid_out | output | 1 | Load result is valid |
| ld_data | output | 8 | Corrected data word |
| ld_syndrome | output | 4 | Syndrome of the fetched codeword |
| ld_err | output | 1 | Syndrome was nonzero |
| ld_par_fix | output | 1 | A parity bit was found flipped |
| ld_uncorr | output | 1 | Syndrome names no codeword position |

## Verification
Every stimulus word is first checked on the store path. It is then fed back either clean or with one position flipped, covering all twelve positions across the table. This tells apart a wrong parity coverage, a wrong data placement and a wrong flip target. Flipping a parity position separates the parity-fix path from data correction. Pairs of flips chosen to give syndromes 13, 14 and 15 exercise the out-of-range class, where the data must stay untouched. Directed steps check the idle hold of the outputs, a back-to-back load, and a reset in the middle of traffic.

// File: rtl/sec_pkg.sv
package sec_pkg;

  localparam int DATA_W = 8;

  function automatic int par_bits_for(int m);
    int k;
    k = 1;
    while (((1 << k) - 1) < (m + k)) k++;
    return k;
  endfunction

  localparam int PAR_W  = par_bits_for(DATA_W);
  localparam int CODE_W = DATA_W + PAR_W;

  typedef logic [DATA_W-1:0] data_t;
  typedef logic [PAR_W-1:0]  par_t;
  typedef logic [CODE_W-1:0] code_t;

  function automatic logic is_pow2(int p);
    return (p > 0) && ((p & (p - 1)) == 0);
  endfunction

  // scatter data bits over non-power-of-two positions, parity slots left zero
  function automatic code_t spread_data(data_t d);
    code_t c;
    int    idx;
    c   = '0;
    idx = 0;
    for (int p = 1; p <= CODE_W; p++) begin
      if (!is_pow2(p)) begin
        c[p-1] = d[idx];
        idx++;
      end
    end
    return c;
  endfunction

  function automatic data_t gather_data(code_t c);
    data_t d;
    int    idx;
    d   = '0;
    idx = 0;
    for (int p = 1; p <= CODE_W; p++) begin
      if (!is_pow2(p)) begin
        d[idx] = c[p-1];
        idx++;
      end
    end
    return d;
  endfunction

  // XOR of the position numbers of all set data bits gives the parity word
  function automatic par_t parity_of(data_t d);
    code_t c;
    par_t  q;
    c = spread_data(d);
    q = '0;
    for (int p = 1; p <= CODE_W; p++) begin
      if (c[p-1]) q = q ^ par_t'(p);
    end
    return q;
  endfunction

endpackage

// File: rtl/sec_rst_sync.sv
module sec_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q <= 2'b00;
    else        stage_q <= {stage_q[0], 1'b1};
  end

  assign rst_sync_n = stage_q[1];
endmodule

// File: rtl/sec_encoder.sv
module sec_encoder
  import sec_pkg::*;
(
  input  data_t d_in,
  output code_t code_out
);
  par_t par;

  assign par = parity_of(d_in);

  always_comb begin
    code_out = spread_data(d_in);
    for (int k = 0; k < PAR_W; k++) begin
      code_out[(1 << k) - 1] = par[k];
    end
  end
endmodule

// File: rtl/sec_syndrome.sv
module sec_syndrome
  import sec_pkg::*;
(
  input  code_t code_in,
  output par_t  syn
);
  par_t stored;

  for (genvar k = 0; k < PAR_W; k++) begin : g_pick
    assign stored[k] = code_in[(1 << k) - 1];
  end

  assign syn = stored ^ parity_of(gather_data(code_in));
endmodule

// File: rtl/sec_corrector.sv
module sec_corrector
  import sec_pkg::*;
(
  input  code_t code_in,
  input  par_t  syn,
  output data_t d_out,
  output logic  data_fix,
  output logic  par_fix,
  output logic  uncorr
);
  code_t fixed;

  always_comb begin
    fixed    = code_in;
    data_fix = 1'b0;
    par_fix  = 1'b0;
    uncorr   = (syn != '0);
    for (int p = 1; p <= CODE_W; p++) begin
      if (syn == par_t'(p)) begin
        uncorr = 1'b0;
        if (is_pow2(p)) begin
          par_fix = 1'b1;
        end else begin
          data_fix   = 1'b1;
          fixed[p-1] = ~code_in[p-1];
        end
      end
    end
    d_out = gather_data(fixed);
  end
endmodule

// File: rtl/sec12_codec.sv
module sec12_codec
  import sec_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic [7:0]  st_data,
  output logic [11:0] st_code,
  input  logic        ld_valid_in,
  input  logic [11:0] ld_code,
  output logic        ld_valid_out,
  output logic [7:0]  ld_data,
  output logic [3:0]  ld_syndrome,
  output logic        ld_err,
  output logic        ld_par_fix,
  output logic        ld_uncorr
);
  logic  rst_sync_n;
  par_t  syn;
  data_t fix_data;
  logic  fix_d, fix_p, fix_u;

  logic  vld_q, vld_d;
  data_t dat_q, dat_d;
  par_t  syn_q, syn_d;
  logic  err_q, err_d, pfx_q, pfx_d, unc_q, unc_d, dfx_q, dfx_d;

  sec_rst_sync u_rst (.clk(clk), .rst_n(rst_n), .rst_sync_n(rst_sync_n));
  sec_encoder  u_enc (.d_in(st_data), .code_out(st_code));
  sec_syndrome u_syn (.code_in(ld_code), .syn(syn));
  sec_corrector u_fix (
    .code_in(ld_code), .syn(syn), .d_out(fix_data),
    .data_fix(fix_d), .par_fix(fix_p), .uncorr(fix_u)
  );

  // next state: load on valid, hold otherwise
  always_comb begin
    vld_d = ld_valid_in;
    dat_d = dat_q;
    syn_d = syn_q;
    err_d = err_q;
    pfx_d = pfx_q;
    unc_d = unc_q;
    dfx_d = dfx_q;
    if (ld_valid_in) begin
      dat_d = fix_data;
      syn_d = syn;
      err_d = (syn != '0);
      pfx_d = fix_p;
      unc_d = fix_u;
      dfx_d = fix_d;
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      vld_q <= 1'b0;
      dat_q <= '0;
      syn_q <= '0;
      err_q <= 1'b0;
      pfx_q <= 1'b0;
      unc_q <= 1'b0;
      dfx_q <= 1'b0;
    end else begin
      vld_q <= vld_d;
      dat_q <= dat_d;
      syn_q <= syn_d;
      err_q <= err_d;
      pfx_q <= pfx_d;
      unc_q <= unc_d;
      dfx_q <= dfx_d;
    end
  end

  assign ld_valid_out = vld_q;
  assign ld_data      = dat_q;
  assign ld_syndrome  = syn_q;
  assign ld_err       = err_q;
  assign ld_par_fix   = pfx_q;
  assign ld_uncorr    = unc_q;

  a_r8_valid_follows: assert property (@(posedge clk) disable iff (!rst_sync_n)
    ld_valid_in |=> ld_valid_out);
  a_r8_valid_drops: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !ld_valid_in |=> !ld_valid_out);
  a_r8_hold_idle: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !ld_valid_in |=> $stable(ld_data) && $stable(ld_syndrome));
  a_r4_clean_passthru: assert property (@(posedge clk) disable iff (!rst_sync_n)
    ld_valid_in ##1 !ld_err |-> ld_data == gather_data($past(ld_code)));
  a_r6_par_keeps_data: assert property (@(posedge clk) disable iff (!rst_sync_n)
    ld_valid_in ##1 ld_par_fix |-> ld_data == gather_data($past(ld_code)));
  a_r7_uncorr_keeps_data: assert property (@(posedge clk) disable iff (!rst_sync_n)
    ld_valid_in ##1 ld_uncorr |-> ld_data == gather_data($past(ld_code)) && ld_err);
  a_r5_one_class: assert property (@(posedge clk) disable iff (!rst_sync_n)
    ld_valid_out |-> $onehot0({dfx_q, ld_par_fix, ld_uncorr}));
  a_r9_reset_quiet: assert property (@(posedge clk)
    !rst_sync_n |=> !ld_valid_out);
endmodule

// File: tb/test_sec12_codec.sv
module test_sec12_codec;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [7:0]  st_data;
  logic [11:0] st_code;
  logic        ld_valid_in;
  logic [11:0] ld_code;
  logic        ld_valid_out;
  logic [7:0]  ld_data;
  logic [3:0]  ld_syndrome;
  logic        ld_err, ld_par_fix, ld_uncorr;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  always #10 clk = ~clk;

  sec12_codec i_sec12_codec (
    .clk(clk), .rst_n(rst_n), .st_data(st_data), .st_code(st_code),
    .ld_valid_in(ld_valid_in), .ld_code(ld_code), .ld_valid_out(ld_valid_out),
    .ld_data(ld_data), .ld_syndrome(ld_syndrome), .ld_err(ld_err),
    .ld_par_fix(ld_par_fix), .ld_uncorr(ld_uncorr)
  );

  // {data, flip position a, flip position b}; 0 = no flip
  localparam int NV = 18;
  localparam logic [15:0] VEC [NV] = '{
    {8'hA5, 4'd0,  4'd0}, {8'h00, 4'd0,  4'd0}, {8'hFF, 4'd0,  4'd0},
    {8'h3C, 4'd6,  4'd0}, {8'hA5, 4'd1,  4'd0}, {8'hA5, 4'd2,  4'd0},
    {8'h5A, 4'd4,  4'd0}, {8'h5A, 4'd8,  4'd0}, {8'hC3, 4'd3,  4'd0},
    {8'hC3, 4'd12, 4'd0}, {8'h96, 4'd9,  4'd0}, {8'h69, 4'd11, 4'd0},
    {8'h7E, 4'd5,  4'd0}, {8'hE7, 4'd7,  4'd0}, {8'h18, 4'd10, 4'd0},
    {8'hF0, 4'd1,  4'd12}, {8'h0F, 4'd2, 4'd12}, {8'h81, 4'd3, 4'd12}
  };

  function automatic logic [11:0] ref_enc(logic [7:0] d);
    logic p1, p2, p4, p8;
    p1 = d[0] ^ d[1] ^ d[3] ^ d[4] ^ d[6];
    p2 = d[0] ^ d[2] ^ d[3] ^ d[5] ^ d[6];
    p4 = d[1] ^ d[2] ^ d[3] ^ d[7];
    p8 = d[4] ^ d[5] ^ d[6] ^ d[7];
    return {d[7], d[6], d[5], d[4], p8, d[3], d[2], d[1], p4, d[0], p2, p1};
  endfunction

  function automatic logic [7:0] ref_data(logic [11:0] c);
    return {c[11], c[10], c[9], c[8], c[6], c[5], c[4], c[2]};
  endfunction

  function automatic logic [11:0] flip(logic [11:0] c, logic [3:0] p);
    logic [11:0] r;
    r = c;
    if (p != 0) r[p-1] = ~r[p-1];
    return r;
  endfunction

  task automatic check(string req, logic [15:0] act, logic [15:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic load(logic [11:0] c);
    @(negedge clk);
    ld_code     = c;
    ld_valid_in = 1'b1;
    @(negedge clk);
    ld_valid_in = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; st_data = '0; ld_valid_in = 1'b0; ld_code = '0;
    repeat (3) @(negedge clk);
    // R9: zero state during reset
    check("R9 reset valid", {15'd0, ld_valid_out}, 16'd0);
    check("R9 reset outputs", {ld_data, ld_syndrome, ld_err, ld_par_fix, ld_uncorr, 1'b0}, 16'd0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check("R9 idle after release", {ld_data, ld_syndrome, ld_err, ld_par_fix, ld_uncorr, ld_valid_out}, 16'd0);

    for (int i = 0; i < NV; i++) begin
      logic [7:0]  d;
      logic [3:0]  a, b, s;
      logic [11:0] c;
      logic [7:0]  ed;
      logic        ep, eu;
      d = VEC[i][15:8]; a = VEC[i][7:4]; b = VEC[i][3:0];
      @(negedge clk);
      st_data = d;
      #1;
      check("R1 R2 encoder", {4'd0, st_code}, {4'd0, ref_enc(d)});
      c  = flip(flip(ref_enc(d), a), b);
      s  = a ^ b;
      ep = (s == 1 || s == 2 || s == 4 || s == 8);
      eu = (s >= 13);
      ed = (s == 0 || ep || eu) ? ref_data(c) : d;
      load(c);
      check("R8 valid out", {15'd0, ld_valid_out}, 16'd1);
      check("R3 syndrome", {12'd0, ld_syndrome}, {12'd0, s});
      if (s == 0)      check("R4 clean data", {8'd0, ld_data}, {8'd0, ed});
      else if (ep)     check("R6 parity flip data", {8'd0, ld_data}, {8'd0, ed});
      else if (eu)     check("R7 uncorrectable data", {8'd0, ld_data}, {8'd0, ed});
      else             check("R5 corrected data", {8'd0, ld_data}, {8'd0, ed});
      check("R4 R5 R6 R7 flags", {13'd0, ld_err, ld_par_fix, ld_uncorr},
            {13'd0, s != 0, ep, eu});
    end

    // R8: outputs hold and valid drops while idle
    begin
      logic [7:0] held;
      held = ld_data;
      ld_code = 12'hFFF;
      repeat (2) @(negedge clk);
      check("R8 valid low idle", {15'd0, ld_valid_out}, 16'd0);
      check("R8 data held idle", {8'd0, ld_data}, {8'd0, held});
    end

    // R8: back-to-back loads, each result one cycle later
    @(negedge clk);
    ld_code = flip(ref_enc(8'h11), 4'd9); ld_valid_in = 1'b1;
    @(negedge clk);
    check("R8 first of pair", {8'd0, ld_data}, 16'h0011);
    ld_code = ref_enc(8'h22);
    @(negedge clk);
    ld_valid_in = 1'b0;
    check("R8 second of pair", {7'd0, ld_valid_out, ld_data}, 16'h0122);

    // R9: reset in the middle of traffic clears outputs
    load(flip(ref_enc(8'h44), 4'd3));
    rst_n = 1'b0;
    #1;
    check("R9 async clear", {ld_data, ld_syndrome, ld_err, ld_par_fix, ld_uncorr, ld_valid_out}, 16'd0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R9 still held after release", {15'd0, ld_valid_out}, 16'd0);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule